// File: doc/BRIEF.md
# Lock Status Tracker

This block keeps the lock bit and the sticky loss-of-lock status of a frequency-locked loop. A separate lock detector supplies a raw lock indication. The block's job is to tell the two kinds of lock loss apart:

- An expected loss follows a software change to the loop configuration. It drops the lock bit but records nothing.
- An unexpected loss is recorded in a sticky flag. Unexpected losses are a raw lock failure while the loop is locked, a stop that halts the clocks while locked, and a clock loss reported by the monitor.

The block also keeps the loss-of-clock flag. Both flags are cleared by the same read-then-write sequence. The two flags are then mapped to an interrupt request or a reset request, according to the two reset enables.

The lock bit is driven by a five-state machine:

- TRACK: the lock bit copies the raw indication.
- HOLD_FALL: the lock bit is held low until the raw indication drops.
- HOLD_RISE: the lock bit is held low until the raw indication comes back.
- STOP_LOCKED: clocks are stopped, and the loop was locked when they stopped.
- STOP_UNLOCKED: clocks are stopped, and the loop was not locked when they stopped.

The transitions are:

- cfg_change: TRACK goes to HOLD_FALL or HOLD_RISE.
- clk_loss: TRACK goes to HOLD_FALL or HOLD_RISE.
- raw_drop: HOLD_FALL goes to HOLD_RISE.
- raw_return: HOLD_RISE goes to TRACK.
- stop_entry: TRACK, HOLD_FALL or HOLD_RISE goes to a STOP state.
- wakeup: either STOP state goes to TRACK.

Mode encoding (`mode`):

| Code | Mode |
|------|------|
| 0 | self-clocked |
| 1 | internal-reference locked |
| 2 | external bypass |
| 3 | external-reference locked |

Modes 1 and 3 are the locked modes.

Top module: `lock_status_tracker`

## Requirements
- R1: After reset, `lock`, `lol_sts`, `loc_sts`, `irq` and `rst_req` are all 0.
- R2: In TRACK, `lock` equals `raw_lock` as sampled at the previous clock edge.
- R3: A pulse on `wr_mult_chg` or `wr_msel_chg` drops `lock` at the next edge. `lock` stays 0 until `raw_lock` has been low for one edge and high again, and `lol_sts` is not set.
- R4: A pulse on `wr_trim_chg` acts like R3 only in mode 1. In modes 0, 2 and 3 it leaves `lock` unchanged.
- R5: In TRACK, `raw_lock` low while `lock` is 1 sets `lol_sts` in modes 1 and 3 only.
- R6: `stop_req` forces `lock` to 0 until `wake`. On `wake`, `lol_sts` is set only if `lock` was 1 in mode 1 or 3 when the stop was taken.
- R7: `loc_event` always sets `loc_sts`. In mode 1 or 3 it also sets `lol_sts` and drops `lock` as in R3.
- R8: A pulse on `flag_clr_wr` clears both flags only if `stat_rd` was pulsed at an earlier edge since the last clear. Otherwise it has no effect.
- R9: `rst_req` = (`lol_sts` & `lol_rst_en`) | (`loc_sts` & `loc_rst_en`). `irq` = the flags whose reset enable is 0, ORed, and forced to 0 while `rst_req` is 1.
- R10: With `lol_rst_en`=1 and `loc_rst_en`=0, a `loc_event` in a locked mode yields `rst_req`=1 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_lock | input | 1 | Lock indication from the lock detector |
| wr_mult_chg | input | 1 | Pulse: write changed the multiplier field |
| wr_msel_chg | input | 1 | Pulse: write changed the mode-select field |
| wr_trim_chg | input | 1 | Pulse: write changed the trim field |
| stop_req | input | 1 | Pulse: clocks are being stopped |
| wake | input | 1 | Pulse: clocks restart after stop |
| loc_event | input | 1 | Pulse: loss of clock from the monitor |
| mode | input | MODE_W | Current operating mode |
| lol_rst_en | input | 1 | Loss of lock requests reset instead of interrupt |
| loc_rst_en | input | 1 | Loss of clock requests reset instead of interrupt |
| stat_rd | input | 1 | Pulse: status register read |
| flag_clr_wr | input | 1 | Pulse: write of 1 to the interrupt flag |
| lock | output | 1 | Lock bit |
| lol_sts | output | 1 | Sticky loss-of-lock status |
| loc_sts | output | 1 | Sticky loss-of-clock status |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request |

## Verification
The bench builds the block with its default parameters:

- MODE_W of 2, so there are only four modes.
- Modes 1 and 3 are marked locked.
- Only mode 1 is sensitive to trim writes.

With this small set, the bench sweeps every mode against every event kind: trim write, raw lock failure, stop with and without lock, and clock loss. It also sweeps all four reset-enable pairs against both flag patterns. Every expected lock, flag, interrupt and reset value is computed arithmetically from the mode masks.

// File: rtl/lst_pkg.sv
package lst_pkg;

    typedef enum logic [2:0] {
        ST_TRACK         = 3'd0,
        ST_HOLD_FALL     = 3'd1,
        ST_HOLD_RISE     = 3'd2,
        ST_STOP_LOCKED   = 3'd3,
        ST_STOP_UNLOCKED = 3'd4
    } lst_state_t;

    // Index of each sticky flag in the flag vector
    localparam int FLAG_LOL = 0;
    localparam int FLAG_LOC = 1;
    localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/lst_lock_fsm.sv
module lst_lock_fsm
    import lst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_lock,
    input  logic       cfg_expected,
    input  logic       mode_locked,
    input  logic       stop_req,
    input  logic       wake,
    input  logic       loc_event,
    output logic       lock_o,
    output logic       lol_set,
    output lst_state_t state_o
);

    lst_state_t state_q, state_d;
    logic       lock_q, lock_d;
    logic       clk_loss;

    assign clk_loss = loc_event && mode_locked;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TRACK;
            lock_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            lock_q  <= lock_d;
        end
    end

    // Next state, lock bit and loss-of-lock set request
    always_comb begin
        state_d = state_q;
        lock_d  = lock_q;
        lol_set = 1'b0;
        unique case (state_q)
            ST_TRACK: begin
                if (stop_req) begin
                    // stop_entry
                    lock_d  = 1'b0;
                    state_d = (lock_q && mode_locked) ? ST_STOP_LOCKED : ST_STOP_UNLOCKED;
                end else if (clk_loss) begin
                    // clk_loss
                    lol_set = 1'b1;
                    lock_d  = 1'b0;
                    state_d = raw_lock ? ST_HOLD_FALL : ST_HOLD_RISE;
                end else if (cfg_expected) begin
                    // cfg_change
                    lock_d  = 1'b0;
                    state_d = raw_lock ? ST_HOLD_FALL : ST_HOLD_RISE;
                end else begin
                    lock_d = raw_lock;
                    if (lock_q && !raw_lock && mode_locked) begin
                        lol_set = 1'b1;
                    end
                end
            end
            ST_HOLD_FALL: begin
                lock_d = 1'b0;
                if (stop_req) begin
                    state_d = ST_STOP_UNLOCKED;
                end else begin
                    lol_set = clk_loss;
                    if (!raw_lock) begin
                        // raw_drop
                        state_d = ST_HOLD_RISE;
                    end
                end
            end
            ST_HOLD_RISE: begin
                lock_d = 1'b0;
                if (stop_req) begin
                    state_d = ST_STOP_UNLOCKED;
                end else if (clk_loss) begin
                    lol_set = 1'b1;
                    state_d = raw_lock ? ST_HOLD_FALL : ST_HOLD_RISE;
                end else if (cfg_expected) begin
                    state_d = raw_lock ? ST_HOLD_FALL : ST_HOLD_RISE;
                end else if (raw_lock) begin
                    // raw_return
                    state_d = ST_TRACK;
                    lock_d  = 1'b1;
                end
            end
            ST_STOP_LOCKED: begin
                lock_d = 1'b0;
                if (wake) begin
                    // wakeup: clocks had stopped while locked
                    lol_set = 1'b1;
                    state_d = ST_TRACK;
                end
            end
            ST_STOP_UNLOCKED: begin
                lock_d = 1'b0;
                if (wake) begin
                    // wakeup
                    state_d = ST_TRACK;
                end
            end
            default: begin
                state_d = ST_TRACK;
                lock_d  = 1'b0;
            end
        endcase
    end

    assign lock_o  = lock_q;
    assign state_o = state_q;

endmodule

// File: rtl/lst_sticky_flags.sv
module lst_sticky_flags
    import lst_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic                 stat_rd,
    input  logic                 flag_clr_wr,
    output logic [NUM_FLAGS-1:0] flag_o
);

    logic armed_q;
    logic clr_ok;

    assign clr_ok = flag_clr_wr && armed_q;

    // Clear arming: a status read must come before the clearing write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (clr_ok) begin
            armed_q <= 1'b0;
        end else if (stat_rd) begin
            armed_q <= 1'b1;
        end
    end

    // One sticky bit per source; a new event wins over a clear
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set_i[g]) begin
                flag_q <= 1'b1;
            end else if (clr_ok) begin
                flag_q <= 1'b0;
            end
        end
        assign flag_o[g] = flag_q;
    end

endmodule

// File: rtl/lst_request_map.sv
module lst_request_map
    import lst_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flag_i,
    input  logic [NUM_FLAGS-1:0] rst_en_i,
    output logic                 irq_o,
    output logic                 rst_req_o
);

    logic [NUM_FLAGS-1:0] to_rst;
    logic [NUM_FLAGS-1:0] to_irq;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_route
        assign to_rst[g] = flag_i[g] &  rst_en_i[g];
        assign to_irq[g] = flag_i[g] & ~rst_en_i[g];
    end

    // A pending reset overrides the interrupt
    assign rst_req_o = |to_rst;
    assign irq_o     = (|to_irq) & ~rst_req_o;

endmodule

// File: rtl/lock_status_tracker.sv
module lock_status_tracker
    import lst_pkg::*;
#(
    parameter int                  MODE_W       = 2,
    parameter logic [2**MODE_W-1:0] LOCKED_MODES = 4'b1010,
    parameter logic [2**MODE_W-1:0] TRIM_MODES   = 4'b0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_lock,
    input  logic              wr_mult_chg,
    input  logic              wr_msel_chg,
    input  logic              wr_trim_chg,
    input  logic              stop_req,
    input  logic              wake,
    input  logic              loc_event,
    input  logic [MODE_W-1:0] mode,
    input  logic              lol_rst_en,
    input  logic              loc_rst_en,
    input  logic              stat_rd,
    input  logic              flag_clr_wr,
    output logic              lock,
    output logic              lol_sts,
    output logic              loc_sts,
    output logic              irq,
    output logic              rst_req
);

    logic                 mode_locked;
    logic                 trim_sens;
    logic                 cfg_expected;
    logic                 lol_set;
    lst_state_t           fsm_state;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] rst_en;

    assign mode_locked  = LOCKED_MODES[mode];
    assign trim_sens    = TRIM_MODES[mode];
    assign cfg_expected = wr_mult_chg || wr_msel_chg || (wr_trim_chg && trim_sens);

    lst_lock_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .raw_lock     (raw_lock),
        .cfg_expected (cfg_expected),
        .mode_locked  (mode_locked),
        .stop_req     (stop_req),
        .wake         (wake),
        .loc_event    (loc_event),
        .lock_o       (lock),
        .lol_set      (lol_set),
        .state_o      (fsm_state)
    );

    assign flag_set[FLAG_LOL] = lol_set;
    assign flag_set[FLAG_LOC] = loc_event;
    assign rst_en[FLAG_LOL]   = lol_rst_en;
    assign rst_en[FLAG_LOC]   = loc_rst_en;

    lst_sticky_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (flag_set),
        .stat_rd     (stat_rd),
        .flag_clr_wr (flag_clr_wr),
        .flag_o      (flags)
    );

    lst_request_map u_map (
        .flag_i    (flags),
        .rst_en_i  (rst_en),
        .irq_o     (irq),
        .rst_req_o (rst_req)
    );

    assign lol_sts = flags[FLAG_LOL];
    assign loc_sts = flags[FLAG_LOC];

endmodule

// File: rtl/lst_checker.sv
module lst_checker
    import lst_pkg::*;
#(
    parameter int                  MODE_W       = 2,
    parameter logic [2**MODE_W-1:0] LOCKED_MODES = 4'b1010
) (
    input logic              clk,
    input logic              rst_n,
    input logic              raw_lock,
    input logic              wr_mult_chg,
    input logic              wr_msel_chg,
    input logic              stop_req,
    input logic              wake,
    input logic [MODE_W-1:0] mode,
    input logic              flag_clr_wr,
    input logic              lock,
    input logic              lol_sts,
    input logic              irq,
    input logic              rst_req,
    input lst_state_t        fsm_state
);

    logic mode_lk;
    assign mode_lk = LOCKED_MODES[mode];

    AST_LOCK_FROM_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> $past(raw_lock)) else $error("lock without raw lock"); // R2

    AST_CFG_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_mult_chg || wr_msel_chg) && !stop_req) |=> !lock) else $error("lock kept after config write"); // R3

    AST_UNEXPECTED_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_TRACK && lock && !raw_lock && mode_lk && !stop_req) |=> lol_sts) else $error("missed loss of lock"); // R5

    AST_WAKE_AFTER_LOCKED_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_STOP_LOCKED && wake) |=> lol_sts) else $error("missed stop loss"); // R6

    AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lol_sts) |-> $past(flag_clr_wr)) else $error("flag dropped without clear"); // R8

    AST_RESET_OVERRIDES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req)) else $error("irq with reset request"); // R9

endmodule

bind lock_status_tracker lst_checker #(
    .MODE_W       (MODE_W),
    .LOCKED_MODES (LOCKED_MODES)
) u_lst_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw_lock    (raw_lock),
    .wr_mult_chg (wr_mult_chg),
    .wr_msel_chg (wr_msel_chg),
    .stop_req    (stop_req),
    .wake        (wake),
    .mode        (mode),
    .flag_clr_wr (flag_clr_wr),
    .lock        (lock),
    .lol_sts     (lol_sts),
    .irq         (irq),
    .rst_req     (rst_req),
    .fsm_state   (fsm_state)
);

// File: tb/lock_status_tracker_bench.sv
`timescale 1ns/1ps
module lock_status_tracker_bench;

    localparam logic [3:0] LK_MASK   = 4'b1010;
    localparam logic [3:0] TRIM_MASK = 4'b0010;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_lock = 1'b0;
    logic       wr_mult_chg = 1'b0, wr_msel_chg = 1'b0, wr_trim_chg = 1'b0;
    logic       stop_req = 1'b0, wake = 1'b0, loc_event = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       lol_rst_en = 1'b0, loc_rst_en = 1'b0;
    logic       stat_rd = 1'b0, flag_clr_wr = 1'b0;
    logic       lock, lol_sts, loc_sts, irq, rst_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lock_status_tracker u_lock_status_tracker (
        .clk(clk), .rst_n(rst_n), .raw_lock(raw_lock),
        .wr_mult_chg(wr_mult_chg), .wr_msel_chg(wr_msel_chg), .wr_trim_chg(wr_trim_chg),
        .stop_req(stop_req), .wake(wake), .loc_event(loc_event), .mode(mode),
        .lol_rst_en(lol_rst_en), .loc_rst_en(loc_rst_en),
        .stat_rd(stat_rd), .flag_clr_wr(flag_clr_wr),
        .lock(lock), .lol_sts(lol_sts), .loc_sts(loc_sts), .irq(irq), .rst_req(rst_req)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n = 1'b0;
        raw_lock = 1'b0;
        mode = m;
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(2'd1);
        chk("R1 lock", lock, 0);
        chk("R1 lol", lol_sts, 0);
        chk("R1 loc", loc_sts, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);

        // R2: lock tracks raw lock one edge later
        raw_lock = 1'b1; tick();
        chk("R2 rise", lock, 1);

        // R3: multiplier and mode-select writes
        for (int w = 0; w < 2; w++) begin
            do_reset(2'd1);
            raw_lock = 1'b1; tick();
            if (w == 0) wr_mult_chg = 1'b1; else wr_msel_chg = 1'b1;
            tick();
            wr_mult_chg = 1'b0; wr_msel_chg = 1'b0;
            chk("R3 drop", lock, 0);
            tick();
            chk("R3 held raw high", lock, 0);
            raw_lock = 1'b0; tick();
            chk("R3 held raw low", lock, 0);
            raw_lock = 1'b1; tick();
            chk("R3 relock", lock, 1);
            chk("R3 no lol", lol_sts, 0);
        end

        // R4: trim write sweep over modes
        for (int m = 0; m < 4; m++) begin
            do_reset(m[1:0]);
            raw_lock = 1'b1; tick();
            wr_trim_chg = 1'b1; tick(); wr_trim_chg = 1'b0;
            chk("R4 lock after trim", lock, TRIM_MASK[m] ? 0 : 1);
            chk("R4 no lol", lol_sts, 0);
        end

        // R5: unexpected raw fall sweep over modes
        for (int m = 0; m < 4; m++) begin
            do_reset(m[1:0]);
            raw_lock = 1'b1; tick();
            raw_lock = 1'b0; tick();
            chk("R5 lol", lol_sts, LK_MASK[m] ? 1 : 0);
            chk("R2 fall", lock, 0);
        end

        // R6: stop/wake sweep over modes and lock state
        for (int m = 0; m < 4; m++) begin
            for (int lk = 0; lk < 2; lk++) begin
                do_reset(m[1:0]);
                raw_lock = lk[0]; tick();
                stop_req = 1'b1; tick(); stop_req = 1'b0;
                chk("R6 lock in stop", lock, 0);
                tick();
                chk("R6 no lol before wake", lol_sts, 0);
                wake = 1'b1; tick(); wake = 1'b0;
                chk("R6 lol on wake", lol_sts, (lk == 1 && LK_MASK[m]) ? 1 : 0);
            end
        end

        // R7: loss-of-clock sweep over modes
        for (int m = 0; m < 4; m++) begin
            do_reset(m[1:0]);
            raw_lock = 1'b1; tick();
            loc_event = 1'b1; tick(); loc_event = 1'b0;
            chk("R7 loc", loc_sts, 1);
            chk("R7 lol", lol_sts, LK_MASK[m] ? 1 : 0);
            chk("R7 lock", lock, LK_MASK[m] ? 0 : 1);
        end

        // R8: clear sequence
        do_reset(2'd1);
        raw_lock = 1'b1; tick();
        loc_event = 1'b1; tick(); loc_event = 1'b0;
        flag_clr_wr = 1'b1; tick(); flag_clr_wr = 1'b0;
        chk("R8 clear without read lol", lol_sts, 1);
        chk("R8 clear without read loc", loc_sts, 1);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        flag_clr_wr = 1'b1; tick(); flag_clr_wr = 1'b0;
        chk("R8 cleared lol", lol_sts, 0);
        chk("R8 cleared loc", loc_sts, 0);
        chk("R8 irq low", irq, 0);

        // R9/R10: reset enable sweep against flag patterns
        for (int re = 0; re < 4; re++) begin
            for (int s = 0; s < 2; s++) begin
                int exp_lol, exp_rst, exp_irq;
                lol_rst_en = re[1];
                loc_rst_en = re[0];
                do_reset(s == 1 ? 2'd1 : 2'd0);
                raw_lock = 1'b1; tick();
                loc_event = 1'b1; tick(); loc_event = 1'b0;
                exp_lol = s;
                exp_rst = (exp_lol & re[1]) | (1 & re[0]);
                exp_irq = (exp_rst == 0) ? ((exp_lol & (1 - re[1])) | (1 - re[0])) : 0;
                if (re == 2 && s == 1) begin
                    chk("R10 rst_req", rst_req, 1);
                    chk("R10 irq", irq, 0);
                end
                chk("R9 rst_req", rst_req, exp_rst);
                chk("R9 irq", irq, exp_irq);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule